// File: doc/BRIEF.md
# Nested Priority Interrupt Resolver

This block sits between an interrupt capture stage and the CPU. It receives sixteen already-masked pending request bits and gives each channel a programmable 4-bit priority, where 15 is the most urgent and 0 the least. Each cycle it picks the most urgent eligible request and drives a registered interrupt line. A request is eligible when it clears two thresholds: an optional lock level, and the priority of the most urgent channel already being serviced.

The CPU takes a request by reading the vector. In the cycle after the read strobe, the vector output holds the winning channel number in binary, or 16 when nothing was eligible. In that same cycle the channel's in-service bit is set and a one-cycle, one-hot clear pulse goes back to the capture stage. An end-of-interrupt strobe carries no channel number. The block itself retires the in-service bit of the most urgent serviced channel, so nested handlers unwind in priority order.

The control is a three-state machine:
- `ST_IDLE`: nothing in service and no line raised.
- `ST_REQ`: the interrupt line is high.
- `ST_SERVICE`: at least one channel is in service and the line is low.

Its transitions are:
- `raise`: IDLE or SERVICE goes to REQ when an eligible request exists.
- `accept`: any state goes to SERVICE, or to IDLE, on a read strobe, depending on whether anything remains in service.
- `withdraw`: REQ goes to SERVICE or IDLE when the eligible request disappears.
- `unwind`: SERVICE goes to IDLE when the last in-service bit is retired.

Top module: `nest_prio_resolver`

## Requirements
- R1: After reset the interrupt line is low, the vector output reads 16, no in-service bit is set, the clear pulse is zero, the lock is disabled, and channel i holds priority i.
- R2: A priority write sets the 4-bit priority of the addressed channel. Among eligible requests, the one with the numerically greatest priority wins, and 15 is the highest.
- R3: While the lock is enabled, a pending request whose priority is less than or equal to the lock level is not eligible.
- R4: When a request arrives in the same cycle as a lock write that blocks it, the interrupt line may go high in the next cycle but is low again in the cycle after that.
- R5: A read strobe with an eligible winner causes three things in the next cycle: the vector output equals the winner's channel number, that channel's in-service bit is set, and the clear output is one-hot on that channel for exactly one cycle.
- R6: A read strobe with no eligible request makes the vector output read 16, leaves the in-service bits unchanged and keeps the clear output zero.
- R7: The interrupt line is registered. It goes high the cycle after an eligible request exists, and it is low in the cycle after any read strobe.
- R8: While any in-service bit is set, only requests with a priority strictly above the highest in-service priority are eligible. Lower or equal requests held pending do not raise the line.
- R9: An end-of-interrupt strobe clears exactly the in-service bit of the channel with the highest priority. With no bit set it has no effect.
- R10: Once every in-service bit has been retired, requests that were blocked and are still pending become eligible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | 16 | Masked pending requests from the capture stage |
| prio_wr_i | input | 1 | Priority write strobe |
| prio_wr_ch_i | input | 4 | Channel addressed by the priority write |
| prio_wr_val_i | input | 4 | New priority value |
| lock_wr_i | input | 1 | Lock register write strobe |
| lock_en_i | input | 1 | Lock enable written with the strobe |
| lock_lvl_i | input | 4 | Lock level written with the strobe |
| vec_rd_i | input | 1 | Vector read strobe, acts as acknowledge |
| eoi_wr_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Interrupt line to the CPU |
| vec_o | output | 5 | Vector captured by the last read (16 means none) |
| ack_clr_o | output | 16 | One-cycle clear pulse to the capture stage |
| isr_o | output | 16 | In-service bits |

## Verification
The assertions assume that no two channels hold the same priority and that priorities are not rewritten while a channel is in service. Without those conditions, the pick of the in-service channel to retire is not well defined. The stimulus keeps the reset priorities, which are all distinct, and later swaps two channels only while nothing is in service. The stimulus also asserts read and end-of-interrupt strobes for single cycles and never in the same cycle. It stands in for the capture stage by dropping a request after it is acknowledged, except where it deliberately holds a request to show that it stays blocked.

// File: rtl/nprr_pkg.sv
`timescale 1ns/1ps
package nprr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REQ     = 2'd1,
        ST_SERVICE = 2'd2
    } nprr_state_e;

endpackage

// File: rtl/nprr_prio_table.sv
`timescale 1ns/1ps
module nprr_prio_table #(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 4,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en_i,
    input  logic [CH_W-1:0]                wr_ch_i,
    input  logic [PRIO_W-1:0]              wr_val_i,
    output logic [NUM_CH-1:0][PRIO_W-1:0]  prio_o
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [PRIO_W-1:0] RST_PRIO = PRIO_W'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_o[g] <= RST_PRIO;
            end else if (wr_en_i && (wr_ch_i == CH_W'(g))) begin
                prio_o[g] <= wr_val_i;
            end
        end
    end

endmodule

// File: rtl/nprr_max_pick.sv
`timescale 1ns/1ps
module nprr_max_pick #(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 4,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]              cand_i,
    input  logic [NUM_CH-1:0][PRIO_W-1:0]  prio_i,
    output logic                           valid_o,
    output logic [CH_W-1:0]                idx_o
);

    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        valid_o   = 1'b0;
        idx_o     = '0;
        best_prio = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cand_i[i] && (!valid_o || (prio_i[i] > best_prio))) begin
                valid_o   = 1'b1;
                idx_o     = CH_W'(i);
                best_prio = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/nprr_isr_track.sv
`timescale 1ns/1ps
module nprr_isr_track #(
    parameter int NUM_CH = 16,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en_i,
    input  logic [CH_W-1:0]   set_idx_i,
    input  logic              clr_en_i,
    input  logic [CH_W-1:0]   clr_idx_i,
    output logic [NUM_CH-1:0] isr_o,
    output logic [NUM_CH-1:0] isr_next_o
);

    always_comb begin
        isr_next_o = isr_o;
        if (clr_en_i) isr_next_o[clr_idx_i] = 1'b0;
        if (set_en_i) isr_next_o[set_idx_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) isr_o <= '0;
        else        isr_o <= isr_next_o;
    end

    AST_ISR_SET_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> isr_o[$past(set_idx_i)]); // R5

    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && !set_en_i) |=> ($countones(isr_o) + 1 == $countones($past(isr_o)))); // R9

    AST_ISR_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en_i && !set_en_i) |=> $stable(isr_o)); // R6

endmodule

// File: rtl/nest_prio_resolver.sv
`timescale 1ns/1ps
module nest_prio_resolver #(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 4,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int VEC_W = CH_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CH-1:0]  pend_i,
    input  logic               prio_wr_i,
    input  logic [CH_W-1:0]    prio_wr_ch_i,
    input  logic [PRIO_W-1:0]  prio_wr_val_i,
    input  logic               lock_wr_i,
    input  logic               lock_en_i,
    input  logic [PRIO_W-1:0]  lock_lvl_i,
    input  logic               vec_rd_i,
    input  logic               eoi_wr_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [NUM_CH-1:0]  ack_clr_o,
    output logic [NUM_CH-1:0]  isr_o
);
    import nprr_pkg::*;

    localparam logic [VEC_W-1:0]  DEF_VEC = VEC_W'(NUM_CH);
    localparam logic [PRIO_W:0]   ONE_X   = (PRIO_W+1)'(1);

    // priority storage
    logic [NUM_CH-1:0][PRIO_W-1:0] prio_tbl;

    nprr_prio_table #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (prio_wr_i),
        .wr_ch_i  (prio_wr_ch_i),
        .wr_val_i (prio_wr_val_i),
        .prio_o   (prio_tbl)
    );

    // lock threshold register
    logic              lock_en_q;
    logic [PRIO_W-1:0] lock_lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_en_q  <= 1'b0;
            lock_lvl_q <= '0;
        end else if (lock_wr_i) begin
            lock_en_q  <= lock_en_i;
            lock_lvl_q <= lock_lvl_i;
        end
    end

    // in-service tracking and its top entry
    logic              isr_top_valid;
    logic [CH_W-1:0]   isr_top_idx;
    logic [NUM_CH-1:0] isr_next;
    logic              win_valid;
    logic [CH_W-1:0]   win_idx;
    logic              ack_take;
    logic              eoi_take;

    assign ack_take = vec_rd_i && win_valid;
    assign eoi_take = eoi_wr_i && isr_top_valid;

    nprr_max_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_isr_pick (
        .cand_i  (isr_o),
        .prio_i  (prio_tbl),
        .valid_o (isr_top_valid),
        .idx_o   (isr_top_idx)
    );

    nprr_isr_track #(.NUM_CH(NUM_CH)) u_isr (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en_i   (ack_take),
        .set_idx_i  (win_idx),
        .clr_en_i   (eoi_take),
        .clr_idx_i  (isr_top_idx),
        .isr_o      (isr_o),
        .isr_next_o (isr_next)
    );

    // eligibility threshold: a channel qualifies when prio >= thr
    logic [PRIO_W:0]   lock_thr;
    logic [PRIO_W:0]   isr_thr;
    logic [PRIO_W:0]   thr;
    logic [NUM_CH-1:0] cand;

    always_comb begin
        lock_thr = lock_en_q     ? ({1'b0, lock_lvl_q} + ONE_X)             : '0;
        isr_thr  = isr_top_valid ? ({1'b0, prio_tbl[isr_top_idx]} + ONE_X) : '0;
        thr      = (lock_thr > isr_thr) ? lock_thr : isr_thr;
        for (int i = 0; i < NUM_CH; i++) begin
            cand[i] = pend_i[i] && ({1'b0, prio_tbl[i]} >= thr);
        end
    end

    nprr_max_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_win_pick (
        .cand_i  (cand),
        .prio_i  (prio_tbl),
        .valid_o (win_valid),
        .idx_o   (win_idx)
    );

    // control state machine
    nprr_state_e state_q, state_d;
    logic        busy_next;

    assign busy_next = |isr_next;

    always_comb begin
        state_d = state_q;
        if (vec_rd_i) begin
            state_d = busy_next ? ST_SERVICE : ST_IDLE;          // accept
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (win_valid) state_d = ST_REQ;               // raise
                end
                ST_REQ: begin
                    if (!win_valid)
                        state_d = busy_next ? ST_SERVICE : ST_IDLE; // withdraw
                end
                ST_SERVICE: begin
                    if (win_valid)       state_d = ST_REQ;         // raise
                    else if (!busy_next) state_d = ST_IDLE;        // unwind
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    assign irq_o = (state_q == ST_REQ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_o     <= DEF_VEC;
            ack_clr_o <= '0;
        end else begin
            ack_clr_o <= '0;
            if (vec_rd_i) begin
                vec_o <= win_valid ? {1'b0, win_idx} : DEF_VEC;
                if (win_valid) ack_clr_o[win_idx] <= 1'b1;
            end
        end
    end

    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd_i |=> !irq_o); // R7

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_clr_o)); // R5

    AST_CLR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_clr_o) |=> (ack_clr_o != $past(ack_clr_o))); // R5

    AST_DEFAULT_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd_i && !win_valid) |=> ((ack_clr_o == '0) && (vec_o == DEF_VEC))); // R6

    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_o <= DEF_VEC); // R6

    AST_IRQ_NEEDS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_valid && !vec_rd_i) |=> !irq_o); // R7

endmodule

// File: tb/nest_prio_resolver_test.sv
`timescale 1ns/1ps
module nest_prio_resolver_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pend = '0;
    logic        prio_wr = 1'b0;
    logic [3:0]  prio_ch = '0;
    logic [3:0]  prio_val = '0;
    logic        lock_wr = 1'b0;
    logic        lock_en = 1'b0;
    logic [3:0]  lock_lvl = '0;
    logic        vec_rd = 1'b0;
    logic        eoi_wr = 1'b0;
    logic        irq;
    logic [4:0]  vec;
    logic [15:0] ack_clr;
    logic [15:0] isr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nest_prio_resolver uut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend),
        .prio_wr_i(prio_wr), .prio_wr_ch_i(prio_ch), .prio_wr_val_i(prio_val),
        .lock_wr_i(lock_wr), .lock_en_i(lock_en), .lock_lvl_i(lock_lvl),
        .vec_rd_i(vec_rd), .eoi_wr_i(eoi_wr),
        .irq_o(irq), .vec_o(vec), .ack_clr_o(ack_clr), .isr_o(isr)
    );

    // {pending[15:0], lock enable, lock level[3:0], expected vector[4:0]}
    localparam logic [25:0] STIM [8] = '{
        {16'h0001, 1'b0, 4'd0,  5'd0},
        {16'h8421, 1'b0, 4'd0,  5'd15},
        {16'h0030, 1'b0, 4'd0,  5'd5},
        {16'h00F0, 1'b1, 4'd5,  5'd7},
        {16'h0030, 1'b1, 4'd5,  5'd16},
        {16'h0000, 1'b0, 4'd0,  5'd16},
        {16'h0104, 1'b1, 4'd2,  5'd8},
        {16'hFFFF, 1'b1, 4'd15, 5'd16}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_read();
        vec_rd = 1'b1;
        tick();
        vec_rd = 1'b0;
    endtask

    task automatic do_eoi();
        eoi_wr = 1'b1;
        tick();
        eoi_wr = 1'b0;
    endtask

    task automatic set_lock(input logic en, input logic [3:0] lvl);
        lock_wr = 1'b1; lock_en = en; lock_lvl = lvl;
        tick();
        lock_wr = 1'b0;
    endtask

    task automatic set_prio(input logic [3:0] ch, input logic [3:0] val);
        prio_wr = 1'b1; prio_ch = ch; prio_val = val;
        tick();
        prio_wr = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 vec", 32'(vec), 32'd16);
        chk("R1 isr", 32'(isr), 32'd0);
        chk("R1 ack_clr", 32'(ack_clr), 32'd0);

        // table walk: R2 R3 R5 R6 R7 under reset priorities
        for (int k = 0; k < 8; k++) begin
            logic [15:0] p;
            logic [4:0]  ev;
            logic [15:0] eclr;
            p  = STIM[k][25:10];
            ev = STIM[k][4:0];
            eclr = (ev == 5'd16) ? 16'h0 : (16'h1 << ev);
            set_lock(STIM[k][9], STIM[k][8:5]);
            pend = p;
            tick(); tick();
            chk($sformatf("R3 R7 row%0d irq", k), 32'(irq), 32'(ev != 5'd16));
            do_read();
            chk($sformatf("R2 R5 R6 row%0d vec", k), 32'(vec), 32'(ev));
            chk($sformatf("R5 R6 row%0d ack_clr", k), 32'(ack_clr), 32'(eclr));
            chk($sformatf("R5 R6 row%0d isr", k), 32'(isr), 32'(eclr));
            chk($sformatf("R7 row%0d irq after read", k), 32'(irq), 32'd0);
            pend = '0;
            tick();
            chk($sformatf("R5 row%0d clr pulse ends", k), 32'(ack_clr), 32'd0);
            do_eoi();
            chk($sformatf("R9 row%0d isr retired", k), 32'(isr), 32'd0);
        end
        set_lock(1'b0, 4'd0);

        // R9 end-of-interrupt with nothing in service
        do_eoi();
        chk("R9 empty eoi isr", 32'(isr), 32'd0);
        chk("R9 empty eoi irq", 32'(irq), 32'd0);

        // R8 R9 R10 nesting, requests held pending
        pend = 16'h0020;
        tick(); tick();
        chk("R7 ch5 irq", 32'(irq), 32'd1);
        do_read();
        chk("R5 ch5 vec", 32'(vec), 32'd5);
        tick();
        chk("R8 equal held pend irq", 32'(irq), 32'd0);
        pend = 16'h0024;
        tick(); tick();
        chk("R8 lower pend irq", 32'(irq), 32'd0);
        pend = 16'h0224;
        tick(); tick();
        chk("R8 higher pend irq", 32'(irq), 32'd1);
        do_read();
        chk("R8 nested vec", 32'(vec), 32'd9);
        chk("R8 nested isr", 32'(isr), 32'h0220);
        pend = 16'h0024;
        tick();
        do_eoi();
        chk("R9 retire highest", 32'(isr), 32'h0020);
        tick();
        chk("R8 still blocked", 32'(irq), 32'd0);
        do_eoi();
        chk("R9 retire last", 32'(isr), 32'h0000);
        tick();
        chk("R10 line returns", 32'(irq), 32'd1);
        do_read();
        chk("R10 blocked wins", 32'(vec), 32'd5);
        pend = 16'h0004;
        tick();
        do_eoi();
        tick();
        do_read();
        chk("R10 lowest wins", 32'(vec), 32'd2);
        pend = '0;
        tick();
        do_eoi();

        // R2 reprogrammed priorities
        set_prio(4'd3, 4'd15);
        set_prio(4'd15, 4'd3);
        pend = 16'h8008;
        tick(); tick();
        do_read();
        chk("R2 swapped top", 32'(vec), 32'd3);
        pend = '0;
        tick();
        do_eoi();
        pend = 16'h8010;
        tick(); tick();
        do_read();
        chk("R2 demoted channel loses", 32'(vec), 32'd4);
        pend = '0;
        tick();
        do_eoi();
        chk("R9 cleanup", 32'(isr), 32'd0);

        // R4 lock write racing a request it blocks
        lock_wr = 1'b1; lock_en = 1'b1; lock_lvl = 4'd8;
        pend = 16'h0040;
        tick();
        lock_wr = 1'b0;
        chk("R4 line may rise", 32'(irq), 32'd1);
        tick();
        chk("R4 line drops", 32'(irq), 32'd0);
        do_read();
        chk("R6 default vec", 32'(vec), 32'd16);
        chk("R6 no clr", 32'(ack_clr), 32'd0);
        chk("R6 isr unchanged", 32'(isr), 32'd0);
        pend = '0;
        set_lock(1'b0, 4'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule